// File: doc/BRIEF.md
# Sign-Magnitude Sequential Multiply/Divide Unit

This unit performs integer multiply and divide on sign-magnitude words, one shift step per clock. It holds a 38-bit accumulator (bit 37 sign, bit 36 Q overflow, bit 35 P overflow, bits 34..0 magnitude) and a 36-bit multiplier-quotient register (bit 35 sign, bits 34..0 magnitude). A caller presents a 36-bit storage operand (bit 35 sign), an 8-bit step count and an operation select, then pulses `start`.

The unit accepts `start` only when it is idle. Some requests finish at once and pulse `done` in the next cycle: a zero step count, a multiply with a zero magnitude, or a divide that is rejected. Any other request raises `busy` for exactly the step count in clocks. `done` then pulses in the cycle in which `busy` falls, and the final signs are written together with the last step. Both registers can be preloaded through load ports while the unit is idle.

Top module: `sm_muldiv_unit`

## Requirements
- R1: A start with step count 0 leaves accumulator and multiplier-quotient unchanged, raises no busy, and pulses done one cycle later with divide-check low.
- R2: A multiply ends with both the accumulator sign (bit 37) and the multiplier-quotient sign (bit 35) equal to the XOR of the starting multiplier-quotient sign and the operand sign (bit 35).
- R3: A multiply with a nonzero count, where the operand magnitude (bits 34..0) or the multiplier-quotient magnitude is zero, runs no steps. It zeroes both magnitudes (accumulator bits 36..0, multiplier-quotient bits 34..0), applies the R2 signs and pulses done one cycle later.
- R4: Each multiply step first adds the operand magnitude into the 37-bit accumulator magnitude (bits 36..0, wrapping at 37 bits) when multiplier-quotient bit 0 is 1. It then shifts the pair accumulator-magnitude:multiplier-quotient-magnitude right by one, so that accumulator bit 0 enters multiplier-quotient bit 34.
- R5: A divide whose 37-bit accumulator magnitude is greater than or equal to the operand magnitude leaves both registers unchanged, runs no steps, and pulses div_check together with done one cycle later.
- R6: Each divide step shifts the pair left by one, with multiplier-quotient bit 34 entering accumulator bit 0. When the accumulator magnitude is then at least the divisor magnitude, the divisor is subtracted and multiplier-quotient bit 0 is set.
- R7: After a divide, the multiplier-quotient sign is the XOR of the starting accumulator sign and the operand sign, and the accumulator sign equals the starting accumulator sign.
- R8: A run that takes steps holds busy high for exactly step-count cycles and then pulses done for one cycle as busy falls. A start that arrives while busy is ignored.
- R9: A load strobe writes its register at the next clock only while the unit is idle and start is low. Loads and operand changes made while busy do not affect the result; after reset both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an operation |
| op_div | input | 1 | 0 multiply, 1 divide |
| step_cnt | input | 8 | Number of shift steps |
| operand | input | 36 | Storage operand, bit 35 sign |
| ac_load | input | 1 | Load strobe for accumulator |
| ac_load_val | input | 38 | Accumulator load value |
| mq_load | input | 1 | Load strobe for multiplier-quotient |
| mq_load_val | input | 36 | Multiplier-quotient load value |
| ac_out | output | 38 | Accumulator contents |
| mq_out | output | 36 | Multiplier-quotient contents |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle completion pulse |
| div_check | output | 1 | Divide rejected, with done |

## Verification
Multiplies are tried with full 35-step runs on maximal magnitudes, with counts that are short or longer than 35, and with Q/P bits set in the starting accumulator. Together these separate a correct 37-bit wrap and right shift from a truncated or sign-polluted one. Divides use dividends just below the divisor, magnitudes that are equal, and a Q bit set above a small divisor, which tell the rejection boundary apart from an off-by-one compare. All four sign combinations are run for both operations to pin down the product, quotient and remainder signs. A directed run also fires start, a load and an operand change mid-operation, which distinguishes captured state from live ports.

// File: rtl/sm_mdu_pkg.sv
package sm_mdu_pkg;
  localparam int MAG_W = 35;
  localparam int ACM_W = MAG_W + 2;
  localparam int AC_W  = ACM_W + 1;
  localparam int MQ_W  = MAG_W + 1;

  typedef struct packed {
    logic [ACM_W-1:0] acm;
    logic [MAG_W-1:0] mqm;
  } pair_t;

  // conditional add then right shift of the pair
  function automatic pair_t mul_step(input pair_t p, input logic [MAG_W-1:0] mc);
    pair_t r;
    logic [ACM_W-1:0] sum;
    sum   = p.mqm[0] ? (p.acm + ACM_W'(mc)) : p.acm;
    r.acm = {1'b0, sum[ACM_W-1:1]};
    r.mqm = {sum[0], p.mqm[MAG_W-1:1]};
    return r;
  endfunction

  // left shift of the pair then restoring compare/subtract
  function automatic pair_t div_step(input pair_t p, input logic [MAG_W-1:0] dv);
    pair_t r;
    r.acm = {p.acm[ACM_W-2:0], p.mqm[MAG_W-1]};
    r.mqm = {p.mqm[MAG_W-2:0], 1'b0};
    if (r.acm >= ACM_W'(dv)) begin
      r.acm    = r.acm - ACM_W'(dv);
      r.mqm[0] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/sm_mdu_ctrl.sv
module sm_mdu_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_div,
  input  logic [CNT_W-1:0] step_cnt,
  input  logic             mul_zero,
  input  logic             div_reject,
  output logic             busy,
  output logic             done,
  output logic             div_check,
  output logic             run_div,
  output logic             ev_accept,
  output logic             ev_begin,
  output logic             ev_zero,
  output logic             ev_step,
  output logic             ev_last
);
  logic [CNT_W-1:0] rem_q;
  logic             cnt_zero;
  logic             shortcut;

  assign ev_accept = start && !busy;
  assign cnt_zero  = (step_cnt == '0);
  assign shortcut  = op_div ? div_reject : mul_zero;
  assign ev_begin  = ev_accept && !cnt_zero && !shortcut;
  assign ev_zero   = ev_accept && !cnt_zero && !op_div && mul_zero;
  assign ev_step   = busy;
  assign ev_last   = busy && (rem_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      div_check <= 1'b0;
      run_div   <= 1'b0;
      rem_q     <= '0;
    end else begin
      done      <= 1'b0;
      div_check <= 1'b0;
      if (ev_accept) begin
        if (cnt_zero || shortcut) begin
          done      <= 1'b1;
          div_check <= !cnt_zero && op_div && div_reject;
        end else begin
          busy    <= 1'b1;
          rem_q   <= step_cnt;
          run_div <= op_div;
        end
      end else if (busy) begin
        rem_q <= rem_q - CNT_W'(1);
        if (ev_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && rem_q != CNT_W'(1)) |=> (busy && rem_q == $past(rem_q) - CNT_W'(1))); // R8
  AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> (done && !busy && !div_check)); // R8
endmodule

// File: rtl/sm_mdu_dpath.sv
module sm_mdu_dpath
  import sm_mdu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MQ_W-1:0] operand,
  input  logic            op_div,
  input  logic            ac_load,
  input  logic [AC_W-1:0] ac_load_val,
  input  logic            mq_load,
  input  logic [MQ_W-1:0] mq_load_val,
  input  logic            busy,
  input  logic            run_div,
  input  logic            ev_accept,
  input  logic            ev_begin,
  input  logic            ev_zero,
  input  logic            ev_step,
  input  logic            ev_last,
  output logic [AC_W-1:0] ac_q,
  output logic [MQ_W-1:0] mq_q,
  output logic            mul_zero,
  output logic            div_reject
);
  logic [MAG_W-1:0] opm_q;
  logic             sgn_dvd_q;
  logic             sgn_res_q;
  logic [MAG_W-1:0] op_mag;
  logic             mul_sign;
  logic             div_sign;
  pair_t            cur_pair;
  pair_t            nxt_pair;
  logic             load_ok;

  assign op_mag     = operand[MAG_W-1:0];
  assign mul_sign   = mq_q[MQ_W-1] ^ operand[MQ_W-1];
  assign div_sign   = ac_q[AC_W-1] ^ operand[MQ_W-1];
  assign mul_zero   = (op_mag == '0) || (mq_q[MAG_W-1:0] == '0);
  assign div_reject = ac_q[ACM_W-1:0] >= ACM_W'(op_mag);
  assign load_ok    = !busy && !ev_accept;

  assign cur_pair.acm = ac_q[ACM_W-1:0];
  assign cur_pair.mqm = mq_q[MAG_W-1:0];
  assign nxt_pair     = run_div ? div_step(cur_pair, opm_q) : mul_step(cur_pair, opm_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_q      <= '0;
      mq_q      <= '0;
      opm_q     <= '0;
      sgn_dvd_q <= 1'b0;
      sgn_res_q <= 1'b0;
    end else if (ev_begin) begin
      opm_q          <= op_mag;
      sgn_dvd_q      <= ac_q[AC_W-1];
      sgn_res_q      <= op_div ? div_sign : mul_sign;
      ac_q[AC_W-1]   <= 1'b0;
      mq_q[MQ_W-1]   <= 1'b0;
    end else if (ev_zero) begin
      ac_q <= {mul_sign, {ACM_W{1'b0}}};
      mq_q <= {mul_sign, {MAG_W{1'b0}}};
    end else if (ev_step) begin
      ac_q[ACM_W-1:0] <= nxt_pair.acm;
      mq_q[MAG_W-1:0] <= nxt_pair.mqm;
      if (ev_last) begin
        ac_q[AC_W-1] <= run_div ? sgn_dvd_q : sgn_res_q;
        mq_q[MQ_W-1] <= sgn_res_q;
      end
    end else if (load_ok) begin
      if (ac_load) ac_q <= ac_load_val;
      if (mq_load) mq_q <= mq_load_val;
    end
  end

  AST_MUL_SIGNS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_last && !run_div) |=> (ac_q[AC_W-1] == mq_q[MQ_W-1])); // R2
  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero |=> (ac_q[ACM_W-1:0] == '0 && mq_q[MAG_W-1:0] == '0)); // R3
  AST_DIV_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_div) |-> (ac_q[ACM_W-1:0] < ACM_W'(opm_q))); // R6
  AST_DIV_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_last && run_div) |=> (ac_q[AC_W-1] == sgn_dvd_q)); // R7
endmodule

// File: rtl/sm_muldiv_unit.sv
module sm_muldiv_unit
  import sm_mdu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             op_div,
  input  logic [CNT_W-1:0] step_cnt,
  input  logic [35:0]      operand,
  input  logic             ac_load,
  input  logic [37:0]      ac_load_val,
  input  logic             mq_load,
  input  logic [35:0]      mq_load_val,
  output logic [37:0]      ac_out,
  output logic [35:0]      mq_out,
  output logic             busy,
  output logic             done,
  output logic             div_check
);
  logic mul_zero, div_reject, run_div;
  logic ev_accept, ev_begin, ev_zero, ev_step, ev_last;

  sm_mdu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .step_cnt(step_cnt), .mul_zero(mul_zero), .div_reject(div_reject),
    .busy(busy), .done(done), .div_check(div_check), .run_div(run_div),
    .ev_accept(ev_accept), .ev_begin(ev_begin), .ev_zero(ev_zero),
    .ev_step(ev_step), .ev_last(ev_last)
  );

  sm_mdu_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .operand(operand), .op_div(op_div),
    .ac_load(ac_load), .ac_load_val(ac_load_val),
    .mq_load(mq_load), .mq_load_val(mq_load_val),
    .busy(busy), .run_div(run_div), .ev_accept(ev_accept),
    .ev_begin(ev_begin), .ev_zero(ev_zero), .ev_step(ev_step),
    .ev_last(ev_last), .ac_q(ac_out), .mq_q(mq_out),
    .mul_zero(mul_zero), .div_reject(div_reject)
  );

  AST_ZERO_COUNT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && step_cnt == '0) |=> ($stable(ac_out) && $stable(mq_out) && done && !busy)); // R1
  AST_DIVCHK_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    div_check |-> ($stable(ac_out) && $stable(mq_out) && done)); // R5
endmodule

// File: tb/sm_muldiv_unit_tb.sv
`timescale 1ns/1ps
module sm_muldiv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_div = 1'b0;
  logic [7:0]  step_cnt = '0;
  logic [35:0] operand = '0;
  logic        ac_load = 1'b0;
  logic [37:0] ac_load_val = '0;
  logic        mq_load = 1'b0;
  logic [35:0] mq_load_val = '0;
  logic [37:0] ac_out;
  logic [35:0] mq_out;
  logic        busy, done, div_check;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  localparam logic [34:0] M35 = {35{1'b1}};

  always #10 clk = ~clk;

  sm_muldiv_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .step_cnt(step_cnt), .operand(operand), .ac_load(ac_load),
    .ac_load_val(ac_load_val), .mq_load(mq_load), .mq_load_val(mq_load_val),
    .ac_out(ac_out), .mq_out(mq_out), .busy(busy), .done(done),
    .div_check(div_check)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: 72-bit product/quotient register built from the requirements
  function automatic logic [73:0] ref_op(input bit dv, input int cnt, input logic [35:0] opd,
                                         input logic [37:0] ac0, input logic [35:0] mq0,
                                         output bit dchk, output int steps);
    logic [71:0] pr;
    logic [36:0] hi;
    logic [34:0] m;
    bit s;
    dchk = 0; steps = 0;
    m = opd[34:0];
    if (cnt == 0) return {ac0, mq0};
    if (!dv) begin
      s = mq0[35] ^ opd[35];
      if (m == 0 || mq0[34:0] == 0) return {s, 37'd0, s, 35'd0};
      steps = cnt;
      pr = {ac0[36:0], mq0[34:0]};
      for (int i = 0; i < cnt; i++) begin
        hi = pr[71:35];
        if (pr[0]) hi = hi + {2'b00, m};
        pr = {1'b0, hi, pr[34:1]};
      end
      return {s, pr[71:35], s, pr[34:0]};
    end else begin
      if (ac0[36:0] >= {2'b00, m}) begin dchk = 1; return {ac0, mq0}; end
      steps = cnt;
      pr = {ac0[36:0], mq0[34:0]};
      for (int i = 0; i < cnt; i++) begin
        pr = pr << 1;
        if (pr[71:35] >= {2'b00, m}) begin
          pr[71:35] = pr[71:35] - {2'b00, m};
          pr[0] = 1'b1;
        end
      end
      return {ac0[37], pr[71:35], ac0[37] ^ opd[35], pr[34:0]};
    end
  endfunction

  task automatic run_op(input bit dv, input int cnt, input logic [35:0] opd,
                        input logic [37:0] ac0, input logic [35:0] mq0,
                        input bit disturb, input string req);
    logic [73:0] exp;
    bit edchk;
    int esteps, bc, t;
    exp = ref_op(dv, cnt, opd, ac0, mq0, edchk, esteps);
    @(negedge clk);
    ac_load = 1; ac_load_val = ac0; mq_load = 1; mq_load_val = mq0;
    @(negedge clk);
    ac_load = 0; mq_load = 0;
    start = 1; op_div = dv; step_cnt = 8'(cnt); operand = opd;
    @(negedge clk);
    start = 0;
    bc = 0; t = 0;
    while (!done && t < 600) begin
      if (busy) bc++;
      if (disturb && bc == 2) begin
        start = 1; op_div = !dv; step_cnt = 8'd3; operand = ~opd;
        ac_load = 1; ac_load_val = ~ac0; mq_load = 1; mq_load_val = ~mq0;
      end else begin
        start = 0; ac_load = 0; mq_load = 0;
      end
      @(negedge clk);
      t++;
    end
    start = 0; ac_load = 0; mq_load = 0;
    chk(done, {req, " done"}, 80'(done), 80'(1));
    chk({ac_out, mq_out} == exp, {req, " result"}, 80'({ac_out, mq_out}), 80'(exp));
    chk(div_check == edchk, {req, " div_check R5"}, 80'(div_check), 80'(edchk));
    chk(bc == esteps, {req, " busy cycles R8"}, 80'(bc), 80'(esteps));
    @(negedge clk);
    chk(!done, {req, " done one cycle R8"}, 80'(done), 80'(0));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [34:0] a, b;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(ac_out == 0 && mq_out == 0 && !busy && !done, "R9 reset", 80'({ac_out, mq_out}), 80'(0));
    // R9 idle load visible
    ac_load = 1; ac_load_val = 38'h2A_1234_5678; mq_load = 1; mq_load_val = 36'h9_8765_4321;
    @(negedge clk);
    ac_load = 0; mq_load = 0;
    chk(ac_out == 38'h2A_1234_5678 && mq_out == 36'h9_8765_4321, "R9 load",
        80'({ac_out, mq_out}), 80'({38'h2A_1234_5678, 36'h9_8765_4321}));
    // R1 zero count
    run_op(0, 0, 36'h8_0000_0003, 38'h3F_0000_0011, 36'h8_0000_0005, 0, "R1 mul cnt0");
    run_op(1, 0, 36'h0_0000_0001, 38'h00_0000_0100, 36'h0_0000_0005, 0, "R1 div cnt0");
    // R3 zero magnitude shortcut, R2 signs
    run_op(0, 35, 36'h8_0000_0007, 38'h1F_FFFF_FFFF, 36'h0_0000_0000, 0, "R3 R2 mq zero");
    run_op(0, 12, 36'h0_0000_0000, 38'h05_5555_5555, 36'h8_1234_5678, 0, "R3 R2 opnd zero");
    // R4 full width maximal, R2 negative
    run_op(0, 35, {1'b1, M35}, 38'h00_0000_0000, {1'b0, M35}, 0, "R4 R2 max mul");
    run_op(0, 50, {1'b1, M35}, 38'h30_0000_0001, {1'b1, M35}, 0, "R4 R2 long mul QP");
    run_op(0, 3, 36'h0_0000_0005, 38'h10_0000_0000, 36'h0_0000_0007, 0, "R4 short mul");
    // R5 rejection boundaries
    run_op(1, 35, 36'h0_0000_1000, 38'h00_0000_1000, 36'h0_0000_0001, 0, "R5 equal");
    run_op(1, 35, 36'h8_0000_0002, 38'h10_0000_0000, 36'h0_0000_0001, 0, "R5 Q set");
    // R6 R7 divides
    run_op(1, 35, 36'h0_0000_1001, 38'h20_0000_1000, 36'h1_2345_6789, 0, "R6 R7 neg dvd");
    run_op(1, 35, {1'b1, M35}, {1'b0, 2'b00, M35 - 35'd1}, {1'b1, M35}, 0, "R6 R7 neg dvr");
    // R8 R9 disturbances during run
    run_op(0, 20, 36'h8_0012_3457, 38'h00_0000_0000, 36'h0_0765_4321, 1, "R8 R9 mul disturb");
    run_op(1, 30, 36'h0_7777_0001, 38'h20_0000_1234, 36'h8_5555_AAAA, 1, "R8 R9 div disturb");
    // random mix
    for (int i = 0; i < 60; i++) begin
      a = 35'({$urandom, $urandom});
      b = 35'({$urandom, $urandom});
      if (i % 2 == 0)
        run_op(0, ($urandom % 48) + 1, {1'($urandom), b},
               {1'($urandom), 2'($urandom), a}, {1'($urandom), 35'({$urandom, $urandom})},
               0, "R2 R4 random mul");
      else begin
        if (b == 0) b = 35'd1;
        run_op(1, ($urandom % 40) + 1, {1'($urandom), b},
               {1'($urandom), 2'b00, (i % 10 == 1) ? b : a % b},
               {1'($urandom), 35'({$urandom, $urandom})}, 0, "R5 R6 R7 random div");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule